// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running 64-bit system count and fires in two steps if software stops servicing it. Software programs a 48-bit offset. The block keeps a 64-bit deadline equal to the count at the moment of arming plus that offset. The first time the count reaches the deadline, the block raises an interrupt and moves the deadline one offset further on. If the count reaches the new deadline before software services the block, it raises a reset request.

Two 4 KB register frames sit on a simple 32-bit memory-mapped bus, and a frame-select input picks between them. The service (kick) frame holds one register. A write to it clears both stage flags and re-arms the deadline. The control frame holds the enable and status word, the two offset words, the two deadline words and a constant identification word. Read data comes back one cycle after the request. Both outputs come straight from state flops.

Top module: `wdg_top`

## Requirements
- R1: After reset, the control/status word, both offset words and both deadline words read as 0, and `wd_irq` and `wd_rst_req` are low.
- R2: A control-frame read at offset 0xFCC returns 0x0001043B. A read at any unmapped control offset returns 0. A read of the kick register returns 0. Read data appears on `rsp_rdata` with `rsp_valid` one cycle after the request.
- R3: The offset low word is at control offset 0x008 and the offset upper word at 0x00C. Only bits 15:0 of the upper word are kept, and they sit above the 32-bit low word to form the 48-bit offset. A write to either word loads the deadline with the current count plus the new offset. The deadline reads back at 0x010 (low word) and 0x014 (high word).
- R4: A write of any data to the kick register (kick frame, offset 0x000) clears both stage flags and loads the deadline with the current count plus the offset. A read of that register changes no state.
- R5: The control/status word is at control offset 0x000, with bit 0 as enable, bit 1 as the first-stage flag and bit 2 as the second-stage flag. Writing bit 0 as 0 clears both flags. Bits 1 and 2 cannot be set by a write.
- R6: While enabled with the first-stage flag clear, a count greater than or equal to the deadline sets the first-stage flag and `wd_irq` at the next edge, and loads the deadline with that count plus the offset.
- R7: While enabled with the first-stage flag set, a count greater than or equal to the deadline sets the second-stage flag and `wd_rst_req`.
- R8: While disabled, neither flag can be set, whatever the count.
- R9: A write to either deadline word takes effect in the comparison on the next cycle.
- R10: A write to an unaligned address (address bits 1:0 not zero) or to an unmapped control offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system count |
| req_valid | input | 1 | Bus access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_frame | input | 1 | 1 = kick frame, 0 = control frame |
| req_addr | input | 12 | Byte offset inside the selected frame |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after a read |
| rsp_valid | output | 1 | Read data valid |
| wd_irq | output | 1 | First-stage timeout interrupt (level) |
| wd_rst_req | output | 1 | Second-stage timeout reset request (level) |

## Verification
The count is driven directly and stopped at chosen values. This places it one below the deadline, exactly on it, and past it, which tells an equal-or-greater compare apart from a strict one. The two timeouts are driven in sequence to separate the first-stage action, which re-arms the deadline, from the second-stage action, which does not. Kicks, disables and kick-frame reads are issued while both flags are set, to show which accesses clear state and which leave it alone. Deadline writes made while enabled are used to show that a software-written deadline is compared at once.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // control frame offsets (kick frame has a single register at 0)
  localparam int A_CS    = 'h000;
  localparam int A_OFFLO = 'h008;
  localparam int A_OFFHI = 'h00C;
  localparam int A_CMPLO = 'h010;
  localparam int A_CMPHI = 'h014;
  localparam int A_ID    = 'hFCC;
  localparam int A_KICK  = 'h000;

  localparam logic [31:0] ID_VALUE = 32'h0001043B;

  localparam int EN_BIT = 0;
  localparam int S1_BIT = 1;
  localparam int S2_BIT = 2;

  typedef struct packed {
    logic kick;
    logic cs;
    logic offlo;
    logic offhi;
    logic cmplo;
    logic cmphi;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RS_NONE, RS_CS, RS_OFFLO, RS_OFFHI, RS_CMPLO, RS_CMPHI, RS_ID
  } rd_sel_t;
endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_frame,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_strobe_t        wr,
  output rd_sel_t           rd_sel,
  output logic              any_wr
);
  logic aligned;
  assign aligned = (req_addr[1:0] == 2'b00);

  always_comb begin
    wr     = '0;
    rd_sel = RS_NONE;
    if (req_valid && aligned) begin
      if (req_frame) begin
        if (req_write && req_addr == ADDR_W'(A_KICK)) wr.kick = 1'b1;
      end else begin
        case (req_addr)
          ADDR_W'(A_CS):    if (req_write) wr.cs    = 1'b1; else rd_sel = RS_CS;
          ADDR_W'(A_OFFLO): if (req_write) wr.offlo = 1'b1; else rd_sel = RS_OFFLO;
          ADDR_W'(A_OFFHI): if (req_write) wr.offhi = 1'b1; else rd_sel = RS_OFFHI;
          ADDR_W'(A_CMPLO): if (req_write) wr.cmplo = 1'b1; else rd_sel = RS_CMPLO;
          ADDR_W'(A_CMPHI): if (req_write) wr.cmphi = 1'b1; else rd_sel = RS_CMPHI;
          ADDR_W'(A_ID):    if (!req_write) rd_sel = RS_ID;
          default: ;
        endcase
      end
    end
  end

  assign any_wr = |wr;
endmodule

// File: rtl/wdg_deadline.sv
module wdg_deadline
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int OFF_W  = 48,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  wr_strobe_t              wr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [CNT_W-1:0]        count,
  input  logic                    rearm,
  output logic [DATA_W-1:0]       off_lo,
  output logic [OFF_W-DATA_W-1:0] off_hi,
  output logic [CNT_W-1:0]        cmp,
  output logic                    hit
);
  localparam int HI_W  = OFF_W - DATA_W;
  localparam int CHI_W = CNT_W - DATA_W;

  logic [OFF_W-1:0] off_next;
  logic             reload;

  always_comb begin
    off_next = {off_hi, off_lo};
    if (wr.offlo) off_next = {off_hi, wdata};
    if (wr.offhi) off_next = {wdata[HI_W-1:0], off_lo};
  end

  assign reload = wr.kick | wr.offlo | wr.offhi | rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_lo <= '0;
      off_hi <= '0;
    end else begin
      if (wr.offlo) off_lo <= wdata;
      if (wr.offhi) off_hi <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (reload) begin
      cmp <= count + CNT_W'(off_next);
    end else begin
      if (wr.cmplo) cmp[DATA_W-1:0]     <= wdata;
      if (wr.cmphi) cmp[CNT_W-1:DATA_W] <= wdata[CHI_W-1:0];
    end
  end

  assign hit = (count >= cmp);
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage (
  input  logic clk,
  input  logic rst,
  input  logic cs_wr,
  input  logic en_wdata,
  input  logic kick,
  input  logic hit,
  input  logic any_wr,
  output logic en,
  output logic s1,
  output logic s2,
  output logic rearm
);
  logic fire;

  // an accepted write owns the cycle; timeout is evaluated on the next one
  assign fire  = en && hit && !any_wr;
  assign rearm = fire && !s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (cs_wr) begin
      en <= en_wdata;
      if (!en_wdata) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end
    end else if (kick) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (fire) begin
      if (!s1) s1 <= 1'b1;
      else     s2 <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int OFF_W  = 48,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  sys_count,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_frame,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_valid,
  output logic              wd_irq,
  output logic              wd_rst_req
);
  localparam int HI_W = OFF_W - DATA_W;

  wr_strobe_t        wr;
  rd_sel_t           rd_sel;
  logic              any_wr;
  logic              en_q, s1_q, s2_q, rearm, hit;
  logic [DATA_W-1:0] off_lo;
  logic [HI_W-1:0]   off_hi;
  logic [CNT_W-1:0]  cmp;
  logic [DATA_W-1:0] rd_val;

  wdg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_frame(req_frame),
    .req_addr(req_addr), .wr(wr), .rd_sel(rd_sel), .any_wr(any_wr)
  );

  wdg_deadline #(.CNT_W(CNT_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dl (
    .clk(clk), .rst(rst), .wr(wr), .wdata(req_wdata), .count(sys_count),
    .rearm(rearm), .off_lo(off_lo), .off_hi(off_hi), .cmp(cmp), .hit(hit)
  );

  wdg_stage u_stg (
    .clk(clk), .rst(rst), .cs_wr(wr.cs), .en_wdata(req_wdata[EN_BIT]),
    .kick(wr.kick), .hit(hit), .any_wr(any_wr),
    .en(en_q), .s1(s1_q), .s2(s2_q), .rearm(rearm)
  );

  always_comb begin
    rd_val = '0;
    case (rd_sel)
      RS_CS: begin
        rd_val[EN_BIT] = en_q;
        rd_val[S1_BIT] = s1_q;
        rd_val[S2_BIT] = s2_q;
      end
      RS_OFFLO: rd_val = off_lo;
      RS_OFFHI: rd_val = DATA_W'(off_hi);
      RS_CMPLO: rd_val = cmp[DATA_W-1:0];
      RS_CMPHI: rd_val = cmp[CNT_W-1:DATA_W];
      RS_ID:    rd_val = ID_VALUE;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_val;
    end
  end

  assign wd_irq     = s1_q;
  assign wd_rst_req = s2_q;
endmodule

// File: rtl/wdg_checks.sv
module wdg_checks #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_frame,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_valid,
  input logic              wd_irq,
  input logic              wd_rst_req,
  input logic              en_q,
  input logic              hit
);
  p_id_const_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_frame && req_addr == ADDR_W'('hFCC))
      |=> (rsp_valid && rsp_rdata == 32'h0001043B));

  p_kick_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_frame && req_addr == '0)
      |=> (!wd_irq && !wd_rst_req));

  p_disable_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_frame && req_addr == '0 && !req_wdata[0])
      |=> (!wd_irq && !wd_rst_req));

  p_stage1_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_irq) |-> $past(hit));

  p_stage2_after_stage1_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst_req) |-> ($past(wd_irq) && $past(hit)));

  p_no_fire_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    ($rose(wd_irq) || $rose(wd_rst_req)) |-> $past(en_q));
endmodule

bind wdg_top wdg_checks #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_frame(req_frame), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .wd_irq(wd_irq),
  .wd_rst_req(wd_rst_req), .en_q(en_q), .hit(hit)
);

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cnt = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_frame = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_valid, wd_irq, wd_rst_req;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  wdg_top u0 (
    .clk(clk), .rst(rst), .sys_count(cnt), .req_valid(req_valid),
    .req_write(req_write), .req_frame(req_frame), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid),
    .wd_irq(wd_irq), .wd_rst_req(wd_rst_req)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [63:0] v);
    @(negedge clk);
    cnt = v;
  endtask

  task automatic bus_wr(input logic frame, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_frame = frame; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic frame, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_frame = frame; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    check("R2 rsp_valid", {63'b0, rsp_valid}, 64'd1);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(0, 12'h000, d); check("R1 cs", d, 0);
    bus_rd(0, 12'h008, d); check("R1 off lo", d, 0);
    bus_rd(0, 12'h00C, d); check("R1 off hi", d, 0);
    bus_rd(0, 12'h010, d); check("R1 cmp lo", d, 0);
    bus_rd(0, 12'h014, d); check("R1 cmp hi", d, 0);
    check("R1 irq", {63'b0, wd_irq}, 0);
    check("R1 rst_req", {63'b0, wd_rst_req}, 0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    bus_rd(0, 12'hFCC, d); check("R2 id", d, 64'h0001043B);
    bus_rd(0, 12'h004, d); check("R2 unmapped 004", d, 0);
    bus_rd(0, 12'hFFC, d); check("R2 unmapped FFC", d, 0);
    bus_rd(1, 12'h000, d); check("R2 kick read", d, 0);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    set_count(64'd1000);
    bus_wr(0, 12'h008, 32'd100);
    bus_rd(0, 12'h010, d); check("R3 cmp lo after off lo", d, 64'd1100);
    bus_rd(0, 12'h014, d); check("R3 cmp hi after off lo", d, 0);
    bus_wr(0, 12'h00C, 32'h0001_0002);
    bus_rd(0, 12'h00C, d); check("R3 off hi keeps 16 bits", d, 64'h2);
    bus_rd(0, 12'h014, d); check("R3 cmp hi 48-bit offset", d, 64'h2);
    bus_rd(0, 12'h010, d); check("R3 cmp lo 48-bit offset", d, 64'd1100);
    bus_wr(0, 12'h00C, 32'd0);
    bus_rd(0, 12'h014, d); check("R3 cmp hi cleared", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_count(64'd5000);
    idle(4);
    check("R8 irq while disabled", {63'b0, wd_irq}, 0);
    bus_rd(0, 12'h000, d); check("R8 cs while disabled", d, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    bus_wr(0, 12'h001, 32'h1);
    bus_rd(0, 12'h000, d); check("R10 unaligned cs write", d, 0);
    bus_wr(0, 12'h004, 32'hFFFF);
    bus_wr(0, 12'h009, 32'd5);
    bus_rd(0, 12'h008, d); check("R10 off lo untouched", d, 64'd100);
    bus_wr(0, 12'h0FC, 32'd9);
    bus_rd(0, 12'h010, d); check("R10 cmp untouched", d, 64'd1100);
  endtask

  task automatic t_stage1();
    logic [31:0] d;
    set_count(64'd500);
    bus_wr(0, 12'h008, 32'd50);
    bus_wr(0, 12'h000, 32'd1);
    idle(3);
    check("R6 no irq before deadline", {63'b0, wd_irq}, 0);
    set_count(64'd549); idle(3);
    check("R6 no irq one below", {63'b0, wd_irq}, 0);
    set_count(64'd550); idle(2);
    check("R6 irq at deadline", {63'b0, wd_irq}, 1);
    check("R6 no rst_req yet", {63'b0, wd_rst_req}, 0);
    bus_rd(0, 12'h000, d); check("R5 cs stage1", d, 64'h3);
    bus_rd(0, 12'h010, d); check("R6 rearmed deadline", d, 64'd600);
  endtask

  task automatic t_stage2();
    logic [31:0] d;
    set_count(64'd600); idle(2);
    check("R7 rst_req", {63'b0, wd_rst_req}, 1);
    check("R7 irq held", {63'b0, wd_irq}, 1);
    bus_rd(0, 12'h000, d); check("R7 cs stage2", d, 64'h7);
    bus_rd(0, 12'h010, d); check("R7 deadline not moved", d, 64'd600);
    bus_rd(1, 12'h000, d); check("R4 kick read zero", d, 0);
    check("R4 kick read keeps rst_req", {63'b0, wd_rst_req}, 1);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    set_count(64'd700);
    bus_wr(1, 12'h000, 32'hDEAD);
    check("R4 irq cleared", {63'b0, wd_irq}, 0);
    check("R4 rst_req cleared", {63'b0, wd_rst_req}, 0);
    bus_rd(0, 12'h000, d); check("R4 cs after kick", d, 64'h1);
    bus_rd(0, 12'h010, d); check("R4 reload", d, 64'd750);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    set_count(64'd750); idle(2);
    check("R6 irq again", {63'b0, wd_irq}, 1);
    bus_wr(0, 12'h000, 32'h6);
    check("R5 disable clears irq", {63'b0, wd_irq}, 0);
    bus_rd(0, 12'h000, d); check("R5 status not writable", d, 0);
    set_count(64'd2000); idle(3);
    check("R8 no irq after disable", {63'b0, wd_irq}, 0);
    check("R8 no rst_req after disable", {63'b0, wd_rst_req}, 0);
  endtask

  task automatic t_cmpwr();
    logic [31:0] d;
    bus_wr(0, 12'h010, 32'd7000);
    bus_wr(0, 12'h014, 32'd0);
    set_count(64'd5000);
    bus_wr(0, 12'h000, 32'd1);
    idle(3);
    check("R9 no irq below written deadline", {63'b0, wd_irq}, 0);
    bus_wr(0, 12'h010, 32'd4000);
    idle(1);
    check("R9 irq after deadline write", {63'b0, wd_irq}, 1);
    bus_rd(0, 12'h010, d); check("R9 rearm from count", d, 64'd5050);
    bus_wr(0, 12'h000, 32'd0);
    bus_wr(0, 12'h000, 32'h7);
    bus_rd(0, 12'h000, d); check("R5 only enable written", d, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_offset();
    t_disabled();
    t_ignore();
    t_stage1();
    t_stage2();
    t_kick();
    t_disable();
    t_cmpwr();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule